// File: doc/BRIEF.md
# Tagged Split-Completion Reorder Buffer

This block sits between a read-request issuer and a completion receiver on a packet link. The link may answer a read with several smaller completion packets. Packets that answer different reads may arrive interleaved. For each read the issuer starts, the block hands out a free tag and records the number of bytes the read will return. Completion beats carry that tag. The block appends each beat to a holding FIFO kept for that tag. It counts the bytes received until the read is whole.

Data leaves on a single ordered stream. Reads are drained strictly in the order they were issued, and a read is drained only once all of its bytes are held. A later read that is already complete waits behind an older one that is not. A tag returns to the free pool once the last beat of its read has been taken from the output. Each holding FIFO is deep enough for the largest read, so the completion input never applies backpressure. Beats that cannot belong to any open read are discarded and raise a sticky error flag.

Top module: `cpl_reorder`

## Requirements
- R1: While fewer than NTAG (8) reads are open, `req_ready` is 1 and `req_tag` shows the lowest-numbered free tag (binary index 0..7). A read is opened on the cycle `req_valid` and `req_ready` are both 1.
- R2: With all eight tags open, `req_ready` is 0. A tag becomes free again in the cycle after the final output beat of its read is accepted. From that cycle `req_ready` is 1 and `req_tag` names the freed tag.
- R3: `req_bytes` is a nonzero multiple of 4, at most 64. Each accepted completion beat adds 4 bytes to its tag's received count. Beats for one tag are kept in the order they arrived.
- R4: A read's data is not offered on the output until its received count equals its `req_bytes`. When that read is the oldest open read, `out_valid` rises one cycle after the edge that accepts its final beat.
- R5: Reads leave the output in issue order. An incomplete oldest read holds back every later read, even ones that are already complete.
- R6: With beats of several reads interleaved in any pattern, each read's output beats equal its completion beats in arrival order.
- R7: `out_tag` carries the tag of the read being drained, and `out_last` is 1 exactly on the final beat of each read.
- R8: A completion beat whose tag is not open is discarded. It sets `err_o` one cycle later, and `err_o` then stays 1 until reset. The discarded beat changes neither the output nor tag allocation.
- R9: A completion beat for an open tag whose byte count is already reached is discarded and sets `err_o`. No extra output beat results.
- R10: A completion beat whose end-of-completion flag disagrees with the byte count sets `err_o`. So does a beat with end-of-completion but without end-of-packet. Such a beat is still stored and forwarded.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_tag` and `out_last` hold their values.
- R12: After reset `req_ready` is 1, `req_tag` is 0, `out_valid` is 0, `err_o` is 0 and `cpl_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Issuer wants to open a read |
| req_bytes | input | 7 | Byte count the read will return |
| req_ready | output | 1 | A tag is free |
| req_tag | output | 3 | Tag granted to the read |
| cpl_valid | input | 1 | Completion beat present |
| cpl_ready | output | 1 | Always 1; completions are never stalled |
| cpl_tag | input | 3 | Tag the beat answers |
| cpl_data | input | 32 | Beat payload (4 bytes) |
| cpl_eop | input | 1 | Beat ends a completion packet |
| cpl_eoc | input | 1 | Beat ends the whole completion for its read |
| out_valid | output | 1 | Ordered output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_tag | output | 3 | Tag of the read being drained |
| out_data | output | 32 | Output payload |
| out_last | output | 1 | Final beat of the read |
| err_o | output | 1 | Sticky flag for discarded or inconsistent beats |

## Verification
The granted tag is combinational and due in the same cycle as the request handshake. The error flag, completion status and freed tag take effect one cycle after the edge that accepts the causing beat. Output beats follow each other with no gap once the oldest read is whole. The bench drives every input shortly after a rising edge and samples every output at the falling edge. Each check therefore reads state that is one register stage past the stimulus edge. The reference is rebuilt from the bench's own record of issued reads: granted tags, sizes, and payloads derived from read and beat indices.

// File: rtl/cro_pkg.sv
package cro_pkg;

   // Life cycle of one tag lane
   typedef enum logic [1:0] {
      LANE_FREE  = 2'd0,   // tag unused
      LANE_FILL  = 2'd1,   // read open, bytes still missing
      LANE_READY = 2'd2    // all bytes held, waiting to drain
   } lane_state_t;

endpackage

// File: rtl/cro_tag_lane.sv
module cro_tag_lane
   import cro_pkg::*;
#(
   parameter int DW     = 32,
   parameter int DEPTH  = 16,
   parameter int BYTE_W = 7,
   parameter int BPB    = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic [BYTE_W-1:0] exp_bytes_i,
   input  logic              push_i,
   input  logic [DW-1:0]     push_data_i,
   input  logic              pop_i,
   output logic [DW-1:0]     pop_data_o,
   output lane_state_t       state_o,
   output logic              fills_o,
   output logic              last_o
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DW-1:0]     mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  fill_cnt;
   logic [BYTE_W-1:0] rx_bytes, exp_bytes;
   logic [BYTE_W:0]   rx_sum;
   lane_state_t       state;

   // byte total after one more beat; equal to the target means this beat completes the read
   assign rx_sum     = {1'b0, rx_bytes} + (BYTE_W+1)'(BPB);
   assign fills_o    = (rx_sum == {1'b0, exp_bytes});
   assign last_o     = (fill_cnt == CNT_W'(1));
   assign pop_data_o = mem[rd_ptr];
   assign state_o    = state;

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_ptr] <= push_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= LANE_FREE;
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         fill_cnt  <= '0;
         rx_bytes  <= '0;
         exp_bytes <= '0;
      end else begin
         if (alloc_i) begin
            rx_bytes  <= '0;
            exp_bytes <= exp_bytes_i;
            state     <= LANE_FILL;
         end
         if (push_i) begin
            wr_ptr   <= wr_ptr + 1'b1;
            rx_bytes <= rx_sum[BYTE_W-1:0];
            if (fills_o) state <= LANE_READY;
         end
         if (pop_i) begin
            rd_ptr <= rd_ptr + 1'b1;
            if (last_o) state <= LANE_FREE;
         end
         // push happens only while filling, pop only when ready: never both
         if (push_i && !pop_i)      fill_cnt <= fill_cnt + 1'b1;
         else if (pop_i && !push_i) fill_cnt <= fill_cnt - 1'b1;
      end
   end

endmodule

// File: rtl/cro_order_queue.sv
module cro_order_queue #(
   parameter int NTAG  = 8,
   parameter int TAG_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             pop_i,
   output logic [TAG_W-1:0] head_o,
   output logic             empty_o,
   output logic             full_o
);

   logic [TAG_W-1:0] slot [NTAG];
   logic [TAG_W-1:0] wp, rp;
   logic [TAG_W:0]   used;

   assign head_o  = slot[rp];
   assign empty_o = (used == '0);
   assign full_o  = (used == (TAG_W+1)'(NTAG));

   always_ff @(posedge clk) begin
      if (push_i) slot[wp] <= tag_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         used <= '0;
      end else begin
         if (push_i) wp <= wp + 1'b1;
         if (pop_i)  rp <= rp + 1'b1;
         if (push_i && !pop_i)      used <= used + 1'b1;
         else if (pop_i && !push_i) used <= used - 1'b1;
      end
   end

endmodule

// File: rtl/cpl_reorder.sv
module cpl_reorder
   import cro_pkg::*;
#(
   parameter  int NTAG   = 8,
   parameter  int DW     = 32,
   parameter  int DEPTH  = 16,
   localparam int TAG_W  = $clog2(NTAG),
   localparam int BPB    = DW / 8,
   localparam int BYTE_W = $clog2(DEPTH * BPB + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BYTE_W-1:0] req_bytes,
   output logic              req_ready,
   output logic [TAG_W-1:0]  req_tag,
   input  logic              cpl_valid,
   output logic              cpl_ready,
   input  logic [TAG_W-1:0]  cpl_tag,
   input  logic [DW-1:0]     cpl_data,
   input  logic              cpl_eop,
   input  logic              cpl_eoc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [TAG_W-1:0]  out_tag,
   output logic [DW-1:0]     out_data,
   output logic              out_last,
   output logic              err_o
);

   // elaboration-time parameter checks
   if (NTAG < 2 || (NTAG & (NTAG - 1)) != 0) begin : g_bad_ntag
      $error("cpl_reorder: NTAG must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cpl_reorder: DEPTH must be a power of two, at least 2");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("cpl_reorder: DW must be a whole number of bytes");
   end

   lane_state_t      lane_st   [NTAG];
   logic [DW-1:0]    lane_data [NTAG];
   logic [NTAG-1:0]  busy, filling, done, fills, lastb;
   logic [NTAG-1:0]  alloc_vec, push_vec, pop_vec;
   logic [TAG_W-1:0] free_tag, q_head;
   logic             q_empty, q_full;
   logic             req_fire, cpl_accept, cpl_bad, out_fire, err_q;

   // ---- tag grant: lowest free lane ----
   always_comb begin
      free_tag = '0;
      for (int i = NTAG - 1; i >= 0; i--) begin
         if (!busy[i]) free_tag = TAG_W'(i);
      end
   end

   assign req_ready = !q_full;
   assign req_tag   = free_tag;
   assign req_fire  = req_valid && req_ready;

   // ---- completion steering ----
   assign cpl_ready  = 1'b1;
   assign cpl_accept = cpl_valid && filling[cpl_tag];
   assign cpl_bad    = cpl_accept && ((cpl_eoc != fills[cpl_tag]) || (cpl_eoc && !cpl_eop));

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else if ((cpl_valid && !cpl_accept) || cpl_bad) err_q <= 1'b1;
   end
   assign err_o = err_q;

   // ---- ordered drain ----
   assign out_valid = !q_empty && done[q_head];
   assign out_tag   = q_head;
   assign out_data  = lane_data[q_head];
   assign out_last  = lastb[q_head];
   assign out_fire  = out_valid && out_ready;

   always_comb begin
      alloc_vec = '0;
      push_vec  = '0;
      pop_vec   = '0;
      if (req_fire)   alloc_vec[free_tag] = 1'b1;
      if (cpl_accept) push_vec[cpl_tag]   = 1'b1;
      if (out_fire)   pop_vec[q_head]     = 1'b1;
   end

   cro_order_queue #(.NTAG(NTAG), .TAG_W(TAG_W)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (req_fire),
      .tag_i   (free_tag),
      .pop_i   (out_fire && out_last),
      .head_o  (q_head),
      .empty_o (q_empty),
      .full_o  (q_full)
   );

   for (genvar g = 0; g < NTAG; g++) begin : g_lane
      cro_tag_lane #(.DW(DW), .DEPTH(DEPTH), .BYTE_W(BYTE_W), .BPB(BPB)) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .alloc_i     (alloc_vec[g]),
         .exp_bytes_i (req_bytes),
         .push_i      (push_vec[g]),
         .push_data_i (cpl_data),
         .pop_i       (pop_vec[g]),
         .pop_data_o  (lane_data[g]),
         .state_o     (lane_st[g]),
         .fills_o     (fills[g]),
         .last_o      (lastb[g])
      );
      assign busy[g]    = (lane_st[g] != LANE_FREE);
      assign filling[g] = (lane_st[g] == LANE_FILL);
      assign done[g]    = (lane_st[g] == LANE_READY);
   end

endmodule

// File: rtl/cro_checker.sv
module cro_checker #(
   parameter  int NTAG   = 8,
   parameter  int DW     = 32,
   parameter  int DEPTH  = 16,
   localparam int TAG_W  = $clog2(NTAG),
   localparam int BPB    = DW / 8,
   localparam int BYTE_W = $clog2(DEPTH * BPB + 1)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [BYTE_W-1:0] req_bytes,
   input logic              req_ready,
   input logic [TAG_W-1:0]  req_tag,
   input logic              cpl_valid,
   input logic [TAG_W-1:0]  cpl_tag,
   input logic              out_valid,
   input logic              out_ready,
   input logic [TAG_W-1:0]  out_tag,
   input logic [DW-1:0]     out_data,
   input logic              out_last,
   input logic              err_o,
   input logic [NTAG-1:0]   busy
);

   // R1: a granted tag is never one that a lane holds
   assert_grant_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy[req_tag]);

   // R1: the tag just granted is not offered again on the next cycle
   assert_no_regrant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !(req_ready && req_tag == $past(req_tag)));

   // R2: lanes all occupied means no grant
   assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy) |-> !req_ready);

   // R3: issuer keeps sizes legal
   assert_legal_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_bytes != '0 && (req_bytes % BYTE_W'(BPB)) == '0
                     && req_bytes <= BYTE_W'(DEPTH * BPB)));

   // R7: a read drains without gaps and without switching tag
   assert_burst_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> (out_valid && out_tag == $past(out_tag)));

   // R8: a beat to an unopened tag raises the flag
   assert_stray_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !busy[cpl_tag]) |=> err_o);

   // R8: the flag is sticky
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R11: a stalled output holds still
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_tag) && $stable(out_last)));

endmodule

bind cpl_reorder cro_checker #(.NTAG(NTAG), .DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_bytes (req_bytes),
   .req_ready (req_ready),
   .req_tag   (req_tag),
   .cpl_valid (cpl_valid),
   .cpl_tag   (cpl_tag),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_tag   (out_tag),
   .out_data  (out_data),
   .out_last  (out_last),
   .err_o     (err_o),
   .busy      (busy)
);

// File: tb/sim_cpl_reorder.sv
`timescale 1ns/1ps
module sim_cpl_reorder;

   localparam int NTAG   = 8;
   localparam int DW     = 32;
   localparam int DEPTH  = 16;
   localparam int TAG_W  = 3;
   localparam int BPB    = 4;
   localparam int BYTE_W = 7;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic [BYTE_W-1:0] req_bytes;
   logic              req_ready;
   logic [TAG_W-1:0]  req_tag;
   logic              cpl_valid;
   logic              cpl_ready;
   logic [TAG_W-1:0]  cpl_tag;
   logic [DW-1:0]     cpl_data;
   logic              cpl_eop;
   logic              cpl_eoc;
   logic              out_valid;
   logic              out_ready;
   logic [TAG_W-1:0]  out_tag;
   logic [DW-1:0]     out_data;
   logic              out_last;
   logic              err_o;

   always #10 clk = ~clk;   // 50 MHz

   cpl_reorder #(.NTAG(NTAG), .DW(DW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_bytes(req_bytes), .req_ready(req_ready), .req_tag(req_tag),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
      .cpl_eop(cpl_eop), .cpl_eoc(cpl_eoc),
      .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
      .out_last(out_last), .err_o(err_o)
   );

   int checks = 0;
   int errors = 0;

   // bench model of issued reads
   int              rq_tag   [1024];
   int              rq_beats [1024];
   int              n_req    = 0;
   int              out_req  = 0;
   int              out_beat = 0;
   bit [NTAG-1:0]   m_busy   = '0;
   int              tag_req  [NTAG];
   int              tag_sent [NTAG];
   bit              hold_ready = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
      end
   endtask

   function automatic logic [31:0] beat_data(input int r, input int b);
      logic [15:0] mix;
      mix = 16'(r * 40503 + b * 977 + 17);
      return {r[7:0], b[7:0], mix};
   endfunction

   function automatic int lowest_free(input bit [NTAG-1:0] m);
      for (int i = 0; i < NTAG; i++) if (!m[i]) return i;
      return -1;
   endfunction

   // ---- output monitor and consumer ----
   initial begin
      bit          prev_stall = 1'b0;
      logic [31:0] prev_data  = '0;
      logic [2:0]  prev_tag   = '0;
      bit          prev_last  = 1'b0;
      out_ready = 1'b0;
      forever begin
         bit fire;
         int free_t;
         free_t = -1;
         @(negedge clk);
         if (rst_n === 1'b1) begin
            if (prev_stall) begin
               // R11: stalled beat unchanged
               chk(out_valid && out_data == prev_data && out_tag == prev_tag && out_last == prev_last,
                   "R11", "stalled output changed", {out_valid, out_data}, {1'b1, prev_data});
            end
            fire       = out_valid && out_ready;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_tag   = out_tag;
            prev_last  = out_last;
            if (fire) begin
               if (out_req >= n_req) begin
                  chk(1'b0, "R9", "beat with no open read", out_data, 0);
               end else begin
                  bit lst;
                  lst = (out_beat == rq_beats[out_req] - 1);
                  chk(out_tag == 3'(rq_tag[out_req]), "R5", "drain order tag",
                      out_tag, rq_tag[out_req]);
                  chk(out_data == beat_data(out_req, out_beat), "R6", "beat payload",
                      out_data, beat_data(out_req, out_beat));
                  chk(out_last == lst, "R7", "last flag", out_last, lst);
                  if (lst) begin
                     free_t   = rq_tag[out_req];
                     out_beat = 0;
                     out_req++;
                  end else begin
                     out_beat++;
                  end
               end
            end
         end else begin
            prev_stall = 1'b0;
         end
         @(posedge clk);
         if (free_t >= 0) m_busy[free_t] = 1'b0;
         #2;
         out_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
      end
   end

   // ---- stimulus tasks ----
   task automatic issue(input int beats, output int tag);
      int e;
      @(posedge clk); #2;
      req_valid = 1'b1;
      req_bytes = BYTE_W'(beats * BPB);
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      e = lowest_free(m_busy);
      chk(int'(req_tag) == e, "R1", "granted tag", req_tag, e);
      tag = req_tag;
      m_busy[tag]   = 1'b1;
      rq_tag[n_req]   = tag;
      rq_beats[n_req] = beats;
      tag_req[tag]    = n_req;
      tag_sent[tag]   = 0;
      n_req++;
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic send(input int tag, input bit eoc, input bit eop, input logic [31:0] d);
      @(posedge clk); #2;
      cpl_valid = 1'b1;
      cpl_tag   = 3'(tag);
      cpl_eoc   = eoc;
      cpl_eop   = eop;
      cpl_data  = d;
      @(posedge clk); #2;
      cpl_valid = 1'b0;
   endtask

   task automatic send_next(input int tag);
      int r, b;
      bit lst;
      r   = tag_req[tag];
      b   = tag_sent[tag];
      lst = (b == rq_beats[r] - 1);
      send(tag, lst, lst || ($urandom % 2 == 1), beat_data(r, b));
      tag_sent[tag] = b + 1;
   endtask

   task automatic drain();
      while (out_req < n_req) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic do_reset();
      @(posedge clk); #2;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
   endtask

   // ---- watchdog ----
   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---- main sequence ----
   initial begin
      int t, ta, tb;
      void'($urandom(32'd20241));
      rst_n = 1'b0; req_valid = 1'b0; req_bytes = '0;
      cpl_valid = 1'b0; cpl_tag = '0; cpl_data = '0; cpl_eop = 1'b0; cpl_eoc = 1'b0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;

      // R12 reset state
      @(negedge clk);
      chk(req_ready == 1'b1, "R12", "req_ready after reset", req_ready, 1);
      chk(req_tag == 3'd0, "R12", "req_tag after reset", req_tag, 0);
      chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
      chk(err_o == 1'b0, "R12", "err_o after reset", err_o, 0);
      chk(cpl_ready == 1'b1, "R12", "cpl_ready after reset", cpl_ready, 1);

      // R4: nothing leaves until the read is whole
      issue(3, t);
      send_next(t); send_next(t);
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", "partial read offered", out_valid, 0);
      send_next(t);
      @(negedge clk);
      chk(out_valid == 1'b1, "R4", "whole read not offered", out_valid, 1);
      drain();

      // R5: incomplete head blocks a complete later read
      issue(2, ta);
      issue(1, tb);
      send_next(tb);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R5", "later read passed head", out_valid, 0);
      send_next(ta); send_next(ta);
      drain();

      // R2: all tags open stalls the grant; one drained read frees its tag
      for (int i = 0; i < NTAG; i++) issue(1, t);
      @(negedge clk);
      chk(req_ready == 1'b0, "R2", "grant while full", req_ready, 0);
      send_next(rq_tag[n_req - NTAG]);
      begin
         int target;
         target = n_req - NTAG + 1;
         while (out_req < target) @(negedge clk);
      end
      @(negedge clk);
      chk(req_ready == 1'b1, "R2", "grant after free", req_ready, 1);
      chk(int'(req_tag) == rq_tag[n_req - NTAG], "R2", "freed tag offered",
          req_tag, rq_tag[n_req - NTAG]);
      for (int i = n_req - NTAG + 1; i < n_req; i++) send_next(rq_tag[i]);
      drain();

      // R3/R6: random interleavings of split completions
      for (int bt = 0; bt < 40; bt++) begin
         int k, left, first;
         k     = 1 + ($urandom % NTAG);
         first = n_req;
         left  = 0;
         for (int i = 0; i < k; i++) begin
            int nb;
            nb = 1 + ($urandom % DEPTH);
            issue(nb, t);
            left += nb;
         end
         while (left > 0) begin
            int pick, tg;
            pick = first + ($urandom % k);
            tg   = rq_tag[pick];
            if (tag_sent[tg] < rq_beats[pick]) begin
               send_next(tg);
               left--;
               if ($urandom % 4 == 0) @(posedge clk);
            end
         end
         drain();
      end

      // R10: early end-of-completion flag raises err, data still forwarded
      issue(2, t);
      send(t, 1'b1, 1'b1, beat_data(tag_req[t], 0));
      tag_sent[t] = 1;
      @(negedge clk);
      chk(err_o == 1'b1, "R10", "flag mismatch not reported", err_o, 1);
      send_next(t);
      drain();
      chk(out_req == n_req, "R10", "mismatched read not forwarded", out_req, n_req);
      do_reset();

      // R9: surplus beat for a read already whole
      hold_ready = 1'b1;
      issue(1, t);
      send_next(t);
      send(t, 1'b1, 1'b1, 32'hDEAD_BEEF);
      @(negedge clk);
      chk(err_o == 1'b1, "R9", "surplus beat not reported", err_o, 1);
      chk(out_valid == 1'b1, "R9", "whole read not offered", out_valid, 1);
      hold_ready = 1'b0;
      drain();
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9", "surplus beat forwarded", out_valid, 0);
      do_reset();

      // R8: stray beat with nothing open
      @(negedge clk);
      chk(err_o == 1'b0, "R8", "err clear before stray beat", err_o, 0);
      send(5, 1'b1, 1'b1, 32'h1234_5678);
      @(negedge clk);
      chk(err_o == 1'b1, "R8", "stray beat not reported", err_o, 1);
      chk(out_valid == 1'b0, "R8", "stray beat forwarded", out_valid, 0);
      issue(1, t);
      chk(t == 0, "R8", "allocation disturbed", t, 0);
      send_next(t);
      drain();
      chk(err_o == 1'b1, "R8", "err not sticky", err_o, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule